// File: doc/BRIEF.md
# Bus Stall Watchdog

This block guards a two-wire serial interface against transfers that hang. A counter advances while the interface and the watchdog are both enabled. Any serial event reported by the interface restarts it. If the counter runs through its full range with no event, a sticky stall flag is raised.

The counter steps on every system clock cycle, or once every four cycles when the slow rate is selected. The slow rate comes from a small prescaler that gives a one-cycle enable, so the whole block runs on the system clock. The stall flag is combined with the interface's own event flag into a single interrupt request. Software removes the stall flag with a clear strobe. The bus protocol itself is handled elsewhere.

Top module: `bus_stall_watchdog`

## Requirements
- R1: After reset, stall_count is 0, stall_flag is 0, and irq_req is 0 while evt_flag is 0.
- R2: With slow_tick_sel = 0, bus_en = 1, stall_en = 1 and evt_flag = 0, stall_count increases by one on every clock edge.
- R3: With slow_tick_sel = 1 and the same enables, stall_count increases by one every fourth edge. The first increment lands on the fourth edge after counting starts or restarts.
- R4: While bus_en or stall_en is 0, stall_count is 0 after the next edge and the prescaler phase restarts.
- R5: An edge with evt_flag = 1 sets stall_count to 0 and restarts the prescaler phase. This takes priority over counting.
- R6: An increment from all ones (16383 at the default width of 14 bits) wraps stall_count to 0 and sets stall_flag on that same edge. Counting then carries on.
- R7: stall_flag stays 1 until an edge where stall_clr = 1 and no wrap occurs, which clears it.
- R8: If stall_clr = 1 on the same edge as a wrap, stall_flag is 1 after that edge.
- R9: irq_req is 1 exactly when evt_flag is 1 or stall_flag is 1. It follows evt_flag without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Serial interface enable |
| stall_en | input | 1 | Watchdog enable |
| slow_tick_sel | input | 1 | 0: step every cycle, 1: step every fourth cycle |
| evt_flag | input | 1 | Serial-event flag from the interface. Restarts the count |
| stall_clr | input | 1 | Software clear strobe for stall_flag |
| stall_count | output | CNT_W | Current watchdog count |
| stall_flag | output | 1 | Sticky stall indication |
| irq_req | output | 1 | Combined interrupt request |

## Verification
A wrong count shows on stall_count after the very next edge, because every cycle has a known expected value. A prescaler that is out of phase shows up within four cycles as an increment that comes too early or too late. A wrong flag state shows on stall_flag and irq_req at the wrap edge, or on the edge after a clear. The runs go through whole wraps at both rates, so an error in all-ones detection or in the choice between set and clear is seen in the cycle where it happens.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
   localparam int unsigned CNT_W_DEFAULT    = 14;
   localparam int unsigned DIV_LOG2_DEFAULT = 2;

   typedef enum logic {
      TICK_DIRECT = 1'b0,
      TICK_DIV    = 1'b1
   } tick_src_e;
endpackage

// File: rtl/bsw_prescaler.sv
module bsw_prescaler #(
   parameter int unsigned DIV_LOG2 = bsw_pkg::DIV_LOG2_DEFAULT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                restart,
   input  bsw_pkg::tick_src_e  src,
   output logic                tick
);
   localparam int unsigned     PRE_W    = DIV_LOG2;
   localparam logic [PRE_W-1:0] PRE_LAST = '1;

   generate
      if (DIV_LOG2 < 1 || DIV_LOG2 > 8) begin : g_bad_div
         $error("bsw_prescaler: DIV_LOG2 must lie in 1..8");
      end
   endgenerate

   logic [PRE_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                phase_q <= '0;
      else if (!run || restart)  phase_q <= '0;
      else                       phase_q <= phase_q + PRE_W'(1);
   end

   assign tick = run & ((src == bsw_pkg::TICK_DIRECT) | (phase_q == PRE_LAST));

   // R3: in divided mode two enable pulses are never adjacent
   p_div_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && src == bsw_pkg::TICK_DIV) |=> !(tick && src == bsw_pkg::TICK_DIV));
endmodule

// File: rtl/bsw_counter.sv
module bsw_counter #(
   parameter int unsigned CNT_W = bsw_pkg::CNT_W_DEFAULT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("bsw_counter: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count_q <= '0;
      else if (!run || restart)  count_q <= '0;
      else if (tick)             count_q <= count_q + CNT_W'(1);
   end

   assign wrap  = run & ~restart & tick & (count_q == ALL_ONES);
   assign count = count_q;

   // R4: disabled watchdog holds zero
   p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> count_q == '0);
   // R5: event restarts the count
   p_evt_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && restart) |=> count_q == '0);
   // R2: one step per enable pulse
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && tick) |=> count_q == $past(count_q) + CNT_W'(1));
   // R3: no movement between pulses
   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && !tick) |=> $stable(count_q));
endmodule

// File: rtl/bsw_sticky_flag.sv
module bsw_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (set)  flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
   end

   assign flag = flag_q;

   // R6 / R8: a wrap always leaves the flag set, clear or not
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag_q);
   // R7: sticky without a clear
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);
   // R7: clear takes effect when no wrap competes
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag_q);
   // R6: the flag appears only through a wrap
   p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !set) |=> !flag_q);
endmodule

// File: rtl/bus_stall_watchdog.sv
module bus_stall_watchdog #(
   parameter int unsigned CNT_W    = bsw_pkg::CNT_W_DEFAULT,
   parameter int unsigned DIV_LOG2 = bsw_pkg::DIV_LOG2_DEFAULT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_en,
   input  logic             stall_en,
   input  logic             slow_tick_sel,
   input  logic             evt_flag,
   input  logic             stall_clr,
   output logic [CNT_W-1:0] stall_count,
   output logic             stall_flag,
   output logic             irq_req
);
   logic               run;
   logic               tick;
   logic               wrap;
   bsw_pkg::tick_src_e src_sel;

   assign run     = bus_en & stall_en;
   assign src_sel = slow_tick_sel ? bsw_pkg::TICK_DIV : bsw_pkg::TICK_DIRECT;

   bsw_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (evt_flag),
      .src     (src_sel),
      .tick    (tick)
   );

   bsw_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (evt_flag),
      .tick    (tick),
      .count   (stall_count),
      .wrap    (wrap)
   );

   bsw_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (wrap),
      .clr   (stall_clr),
      .flag  (stall_flag)
   );

   assign irq_req = evt_flag | stall_flag;

   // R9: a newly raised stall flag is visible on the interrupt line
   p_irq_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_flag) |-> irq_req);
   // R6: the flag rises only on the edge where the count wraps to zero
   p_rise_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_flag) |-> stall_count == '0);
endmodule

// File: tb/bus_stall_watchdog_tb_top.sv
module bus_stall_watchdog_tb_top;
   localparam int W   = 14;
   localparam logic [W-1:0] MAX = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_en = 1'b0, stall_en = 1'b0, slow_tick_sel = 1'b0;
   logic evt_flag = 1'b0, stall_clr = 1'b0;
   logic [W-1:0] stall_count;
   logic stall_flag, irq_req;

   always #5 clk = ~clk;

   bus_stall_watchdog dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .stall_en(stall_en),
      .slow_tick_sel(slow_tick_sel), .evt_flag(evt_flag), .stall_clr(stall_clr),
      .stall_count(stall_count), .stall_flag(stall_flag), .irq_req(irq_req)
   );

   int vectors = 0;
   int miscompares = 0;

   logic [W-1:0] q_cnt[$];
   logic         q_flag[$];
   logic         q_irq[$];
   string        q_tag[$];

   logic [1:0]   m_pre = '0;
   logic [W-1:0] m_cnt = '0;
   logic         m_flag = 1'b0;

   task automatic compare(input logic [W-1:0] ec, input logic ef, input logic ei, input string tag);
      vectors++;
      if (stall_count !== ec) begin
         miscompares++;
         $display("FAIL %s stall_count actual=%0d expected=%0d", tag, stall_count, ec);
      end
      if (stall_flag !== ef) begin
         miscompares++;
         $display("FAIL %s stall_flag actual=%0b expected=%0b", tag, stall_flag, ef);
      end
      if (irq_req !== ei) begin
         miscompares++;
         $display("FAIL R9 (%s) irq_req actual=%0b expected=%0b", tag, irq_req, ei);
      end
   endtask

   // driver: apply one cycle of stimulus and queue the state expected after the edge
   task automatic step(input logic be, input logic se, input logic sl,
                       input logic ev, input logic cl, input string tag);
      logic run, tk, wr;
      @(negedge clk);
      bus_en = be; stall_en = se; slow_tick_sel = sl; evt_flag = ev; stall_clr = cl;
      run = be & se;
      wr  = 1'b0;
      if (!run || ev) begin
         m_pre = '0;
         m_cnt = '0;
      end else begin
         tk = !sl || (m_pre == 2'd3);
         wr = tk && (m_cnt == MAX);
         m_pre = m_pre + 2'd1;
         if (tk) m_cnt = m_cnt + W'(1);
      end
      if (wr)      m_flag = 1'b1;
      else if (cl) m_flag = 1'b0;
      q_cnt.push_back(m_cnt);
      q_flag.push_back(m_flag);
      q_irq.push_back(ev | m_flag);
      q_tag.push_back(tag);
   endtask

   // monitor: compare just after each edge, before the next drive
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_cnt.size() > 0)
            compare(q_cnt.pop_front(), q_flag.pop_front(), q_irq.pop_front(), q_tag.pop_front());
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      miscompares++;
      $display("FAIL R2 watchdog expired: actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare('0, 1'b0, 1'b0, "R1");                  // R1 reset state

      for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, "R4");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R4");
      for (int i = 0; i < 100; i++) step(1, 1, 0, 0, 0, "R2");
      step(1, 1, 0, 1, 0, "R5");                      // event restarts, irq from event (R9)
      for (int i = 0; i < 50; i++) step(1, 1, 0, 0, 0, "R2");
      step(1, 0, 0, 0, 0, "R4");                      // watchdog enable dropped
      for (int i = 0; i < 41; i++) step(1, 1, 1, 0, 0, "R3");
      step(1, 1, 1, 1, 0, "R5");                      // restart mid-phase
      for (int i = 0; i < 22; i++) step(1, 1, 1, 0, 0, "R3");
      step(0, 1, 1, 0, 0, "R4");                      // interface enable dropped
      for (int i = 0; i < 9; i++) step(1, 1, 1, 0, 0, "R4");

      step(1, 1, 0, 1, 0, "R5");
      for (int i = 0; i < 16384 + 12; i++) step(1, 1, 0, 0, 0, "R6");
      step(1, 1, 0, 1, 0, "R9");                      // event while flag set
      for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R7");
      step(1, 1, 0, 0, 1, "R7");                      // clear without wrap
      for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R7");

      while (m_cnt != MAX) step(1, 1, 0, 0, 0, "R6");
      step(1, 1, 0, 0, 1, "R8");                      // clear on the wrap edge
      for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R7");

      step(1, 1, 1, 1, 1, "R7");                      // clear and restart for slow run
      for (int i = 0; i < 4 * 16384 + 6; i++) step(1, 1, 1, 0, 0, "R6");
      step(0, 0, 0, 0, 0, "R4");

      repeat (3) @(posedge clk);
      #3;
      finish_run();
   end
endmodule